// File: doc/BRIEF.md
# Auto-Acknowledging Prioritized Interrupt Controller

This block gathers a parameterized number of level-sensitive interrupt lines and steers each one to one of a small group of processors. Every line carries a single mask bit and a software pending bit that is ORed with its hardware input. Every line also has a one-hot register that names its destination processor. Each processor drives one interrupt output, which is high while any source that is routed to it and unmasked is pending.

A processor services interrupts by reading its event register. The value read names the most urgent source eligible for that processor. The same read also acknowledges the source by setting its mask, so no separate claim step exists. Priority is fixed. The two inter-processor interrupts of the reading processor come first ("other" ahead of "self"), and then the hardware lines, lowest number first. Software re-enables a line by clearing its mask once the handler is done.

Each processor has two inter-processor interrupts, "other" and "self". Each has its own pending and mask bits, and it is driven through send, acknowledge, mask-set and mask-clear registers. Every access carries a processor index. That index selects the "this processor" view for the event, identity and inter-processor registers.

Top module: `autoack_intc`

## Requirements
- R1: After reset every line is masked (a mask word reads all ones over the implemented lines), every software bit is clear, every target register reads 1 (processor 0), both inter-processor interrupts of every processor are masked and not pending, every `cpu_irq` bit is 0 and an event read returns 0.
- R2: A read of offset 0x000 returns NUM_LINES in bits 15:0 and zeros above. A read of offset 0x004 returns the accessing processor index `bus_cpu`.
- R3: A write to 0x100+4*w sets the mask of line 32*w+b for every 1 in bit b. A write to 0x180+4*w clears those masks. Zero bits leave masks unchanged. A read of either address returns mask word w, and bits above the last line read 0.
- R4: A write to 0x200+4*w sets software bits with write-1 semantics, and a write to 0x280+4*w clears them. A read of either address returns software word w. A line is pending while its hardware input is high or its software bit is set, and it is not latched: a line whose input falls before the event read is not reported.
- R5: The target register of line i sits at 0x1000+4*i, and its bits NUM_CPUS-1:0 name processors. A line is eligible for processor c only when bit c is set.
- R6: A read of offset 0x008 returns the event word: bits 31:24 are 0, bits 23:16 give the type (1 = hardware line, 4 = inter-processor), and bits 15:0 give the number (the line index; or 1 = "other", 2 = "self"). The value 0 means no eligible source. The priority order is "other", then "self", then the lowest line number.
- R7: An event read that reports a hardware line sets that line's mask in the next cycle. An event read that returns 0 changes no state.
- R8: A write to 0x00C sets "other" pending at every processor c whose bit c is 1, and bit 31 sets "self" pending at the accessing processor. In the acknowledge register (0x010), mask-set register (0x014) and mask-clear register (0x018), bit 0 selects "other" and bit 31 selects "self". These three act on the accessing processor with write-1 semantics.
- R9: An event read that reports an inter-processor interrupt masks it but leaves it pending. It is reported again after it is unmasked, until it is acknowledged.
- R10: `cpu_irq[c]` is high exactly when processor c has an eligible source, that is, when an event read by c would return a nonzero value.
- R11: Event, identity and inter-processor accesses act only on the processor named by `bus_cpu`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Index of the accessing processor |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the read cycle; state updates at the closing edge |
| hw_irq | input | NUM_LINES | Level-sensitive hardware interrupt lines |
| cpu_irq | output | NUM_CPUS | Interrupt request to each processor |

## Verification
A lost auto-mask shows in the cycle right after an event read. The same line is reported again, and the processor's `cpu_irq` stays high. A wrong priority or a stale pending bit is visible in the value of the next event read. A wrongly held inter-processor pending bit appears only later: the interrupt is missing after an unmask, or it keeps coming back after an acknowledge. The directed sequences therefore read events again after each mask change, which exposes that kind of corruption within one or two accesses.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int unsigned OFS_INFO     = 32'h0000;
   localparam int unsigned OFS_WHOAMI   = 32'h0004;
   localparam int unsigned OFS_EVENT    = 32'h0008;
   localparam int unsigned OFS_IPI_SEND = 32'h000C;
   localparam int unsigned OFS_IPI_ACK  = 32'h0010;
   localparam int unsigned OFS_IPI_MSET = 32'h0014;
   localparam int unsigned OFS_IPI_MCLR = 32'h0018;
   localparam int unsigned OFS_MSET     = 32'h0100;
   localparam int unsigned OFS_MCLR     = 32'h0180;
   localparam int unsigned OFS_SWSET    = 32'h0200;
   localparam int unsigned OFS_SWCLR    = 32'h0280;
   localparam int unsigned OFS_TARGET   = 32'h1000;

   localparam logic [7:0]  EVT_TYPE_HW  = 8'd1;
   localparam logic [7:0]  EVT_TYPE_IPI = 8'd4;
   localparam logic [15:0] IPI_NUM_OTHER = 16'd1;
   localparam logic [15:0] IPI_NUM_SELF  = 16'd2;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_LINE  = 2'd1,
      SRC_OTHER = 2'd2,
      SRC_SELF  = 2'd3
   } src_kind_e;

   typedef struct packed {
      src_kind_e   kind;
      logic [15:0] num;
   } pick_t;

   function automatic logic [31:0] event_word(input pick_t p);
      logic [31:0] w;
      case (p.kind)
         SRC_LINE:  w = {8'd0, EVT_TYPE_HW, p.num};
         SRC_OTHER: w = {8'd0, EVT_TYPE_IPI, IPI_NUM_OTHER};
         SRC_SELF:  w = {8'd0, EVT_TYPE_IPI, IPI_NUM_SELF};
         default:   w = 32'd0;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/intc_line_bank.sv
module intc_line_bank
   import intc_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned NUM_CPUS  = 4,
   localparam int unsigned IDX_W = $clog2(NUM_LINES),
   localparam int unsigned WORDS = (NUM_LINES + 31) / 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [31:0]          wr_addr,
   input  logic [31:0]          wr_data,
   input  logic                 auto_mask_en,
   input  logic [IDX_W-1:0]     auto_mask_idx,
   input  logic [31:0]          rd_addr,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] sw_q,
   output logic [NUM_CPUS-1:0]  tgt_q [NUM_LINES],
   output logic [31:0]          rd_data
);

   logic unused_bank;
   assign unused_bank = ^wr_data;

   // per-line state, one generate slice per line
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      localparam int unsigned W = i / 32;
      localparam int unsigned B = i % 32;
      localparam logic [31:0] A_MSET  = 32'(OFS_MSET  + 4 * W);
      localparam logic [31:0] A_MCLR  = 32'(OFS_MCLR  + 4 * W);
      localparam logic [31:0] A_SWSET = 32'(OFS_SWSET + 4 * W);
      localparam logic [31:0] A_SWCLR = 32'(OFS_SWCLR + 4 * W);
      localparam logic [31:0] A_TGT   = 32'(OFS_TARGET + 4 * i);

      logic bit_w;
      logic auto_hit;
      assign bit_w    = wr_en & wr_data[B];
      assign auto_hit = auto_mask_en & (auto_mask_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q[i] <= 1'b1;
         end else if (auto_hit || (bit_w && wr_addr == A_MSET)) begin
            mask_q[i] <= 1'b1;
         end else if (bit_w && wr_addr == A_MCLR) begin
            mask_q[i] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sw_q[i] <= 1'b0;
         end else if (bit_w && wr_addr == A_SWSET) begin
            sw_q[i] <= 1'b1;
         end else if (bit_w && wr_addr == A_SWCLR) begin
            sw_q[i] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tgt_q[i] <= NUM_CPUS'(1);
         end else if (wr_en && wr_addr == A_TGT) begin
            tgt_q[i] <= wr_data[NUM_CPUS-1:0];
         end
      end
   end

   logic [WORDS*32-1:0] mask_pad;
   logic [WORDS*32-1:0] sw_pad;
   assign mask_pad = (WORDS*32)'(mask_q);
   assign sw_pad   = (WORDS*32)'(sw_q);

   always_comb begin
      rd_data = 32'd0;
      for (int w = 0; w < int'(WORDS); w++) begin
         if (rd_addr == 32'(OFS_MSET + 4 * w) || rd_addr == 32'(OFS_MCLR + 4 * w)) begin
            rd_data = mask_pad[w*32 +: 32];
         end
         if (rd_addr == 32'(OFS_SWSET + 4 * w) || rd_addr == 32'(OFS_SWCLR + 4 * w)) begin
            rd_data = sw_pad[w*32 +: 32];
         end
      end
      for (int i = 0; i < int'(NUM_LINES); i++) begin
         if (rd_addr == 32'(OFS_TARGET + 4 * i)) begin
            rd_data = 32'(tgt_q[i]);
         end
      end
   end

endmodule

// File: rtl/intc_ipi_cell.sv
module intc_ipi_cell (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] send,
   input  logic [1:0] ack,
   input  logic [1:0] mset,
   input  logic [1:0] mclr,
   input  logic [1:0] auto_mask,
   output logic [1:0] elig
);

   // index 0 = "other", index 1 = "self"
   logic [1:0] pend_q;
   logic [1:0] mask_q;

   for (genvar k = 0; k < 2; k++) begin : g_kind
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q[k] <= 1'b0;
         end else if (send[k]) begin
            pend_q[k] <= 1'b1;
         end else if (ack[k]) begin
            pend_q[k] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q[k] <= 1'b1;
         end else if (auto_mask[k] || mset[k]) begin
            mask_q[k] <= 1'b1;
         end else if (mclr[k]) begin
            mask_q[k] <= 1'b0;
         end
      end

      assign elig[k] = pend_q[k] & ~mask_q[k];
   end

endmodule

// File: rtl/intc_pick.sv
module intc_pick
   import intc_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64
) (
   input  logic [NUM_LINES-1:0] line_elig,
   input  logic [1:0]           ipi_elig,
   output pick_t                pick
);

   always_comb begin
      pick = '{kind: SRC_NONE, num: 16'd0};
      for (int i = int'(NUM_LINES) - 1; i >= 0; i--) begin
         if (line_elig[i]) begin
            pick = '{kind: SRC_LINE, num: 16'(i)};
         end
      end
      if (ipi_elig[1]) begin
         pick = '{kind: SRC_SELF, num: IPI_NUM_SELF};
      end
      if (ipi_elig[0]) begin
         pick = '{kind: SRC_OTHER, num: IPI_NUM_OTHER};
      end
   end

endmodule

// File: rtl/autoack_intc.sv
module autoack_intc
   import intc_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned NUM_CPUS  = 4,
   parameter int unsigned ADDR_W    = 14,
   localparam int unsigned CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
   localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [CPU_W-1:0]     bus_cpu,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_LINES-1:0] hw_irq,
   output logic [NUM_CPUS-1:0]  cpu_irq
);

   initial begin
      assert (NUM_LINES >= 2 && NUM_LINES <= 1024)
         else $error("NUM_LINES must lie in 2..1024");
      assert (NUM_CPUS >= 2 && NUM_CPUS <= 16)
         else $error("NUM_CPUS must lie in 2..16");
      assert (ADDR_W >= 13 && ADDR_W <= 32)
         else $error("ADDR_W too narrow for the target block");
   end

   logic [31:0] addr32;
   logic        wr_en;
   logic        rd_en;
   assign addr32 = 32'(bus_addr);
   assign wr_en  = bus_valid & bus_write;
   assign rd_en  = bus_valid & ~bus_write;

   logic hit_event, hit_send, hit_ack, hit_mset, hit_mclr;
   assign hit_event = (addr32 == OFS_EVENT);
   assign hit_send  = (addr32 == OFS_IPI_SEND);
   assign hit_ack   = (addr32 == OFS_IPI_ACK);
   assign hit_mset  = (addr32 == OFS_IPI_MSET);
   assign hit_mclr  = (addr32 == OFS_IPI_MCLR);

   logic [NUM_CPUS-1:0] cpu_sel;
   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_sel
      assign cpu_sel[c] = (bus_cpu == CPU_W'(c));
   end

   // ---------------- line state ----------------
   logic [NUM_LINES-1:0] line_mask;
   logic [NUM_LINES-1:0] line_sw;
   logic [NUM_CPUS-1:0]  line_tgt [NUM_LINES];
   logic [31:0]          bank_rdata;
   logic                 ev_read;
   logic                 auto_line;
   pick_t                acc_pick;

   assign ev_read   = rd_en & hit_event;
   assign auto_line = ev_read & (acc_pick.kind == SRC_LINE);

   intc_line_bank #(
      .NUM_LINES(NUM_LINES),
      .NUM_CPUS (NUM_CPUS)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (addr32),
      .wr_data      (bus_wdata),
      .auto_mask_en (auto_line),
      .auto_mask_idx(acc_pick.num[IDX_W-1:0]),
      .rd_addr      (addr32),
      .mask_q       (line_mask),
      .sw_q         (line_sw),
      .tgt_q        (line_tgt),
      .rd_data      (bank_rdata)
   );

   logic [NUM_LINES-1:0] line_pend;
   assign line_pend = hw_irq | line_sw;

   // ---------------- per-processor slice ----------------
   pick_t cpu_pick [NUM_CPUS];

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic [NUM_LINES-1:0] tgt_col;
      logic [NUM_LINES-1:0] elig;
      logic [1:0]           ipi_elig;
      logic [1:0]           send, ack, mset, mclr, amask;

      for (genvar i = 0; i < NUM_LINES; i++) begin : g_col
         assign tgt_col[i] = line_tgt[i][c];
      end

      assign elig = line_pend & ~line_mask & tgt_col;

      assign send[0]  = wr_en & hit_send & bus_wdata[c];
      assign send[1]  = wr_en & hit_send & bus_wdata[31] & cpu_sel[c];
      assign ack      = {2{wr_en & hit_ack  & cpu_sel[c]}} & {bus_wdata[31], bus_wdata[0]};
      assign mset     = {2{wr_en & hit_mset & cpu_sel[c]}} & {bus_wdata[31], bus_wdata[0]};
      assign mclr     = {2{wr_en & hit_mclr & cpu_sel[c]}} & {bus_wdata[31], bus_wdata[0]};
      assign amask[0] = ev_read & cpu_sel[c] & (cpu_pick[c].kind == SRC_OTHER);
      assign amask[1] = ev_read & cpu_sel[c] & (cpu_pick[c].kind == SRC_SELF);

      intc_ipi_cell u_ipi (
         .clk      (clk),
         .rst_n    (rst_n),
         .send     (send),
         .ack      (ack),
         .mset     (mset),
         .mclr     (mclr),
         .auto_mask(amask),
         .elig     (ipi_elig)
      );

      intc_pick #(
         .NUM_LINES(NUM_LINES)
      ) u_pick (
         .line_elig(elig),
         .ipi_elig (ipi_elig),
         .pick     (cpu_pick[c])
      );

      assign cpu_irq[c] = (|elig) | (|ipi_elig);
   end

   always_comb begin
      acc_pick = '{kind: SRC_NONE, num: 16'd0};
      for (int c = 0; c < int'(NUM_CPUS); c++) begin
         if (cpu_sel[c]) begin
            acc_pick = cpu_pick[c];
         end
      end
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = 32'd0;
      if (rd_en) begin
         if (addr32 == OFS_INFO) begin
            bus_rdata = {16'd0, 16'(NUM_LINES)};
         end else if (addr32 == OFS_WHOAMI) begin
            bus_rdata = 32'(bus_cpu);
         end else if (hit_event) begin
            bus_rdata = event_word(acc_pick);
         end else begin
            bus_rdata = bank_rdata;
         end
      end
   end

   logic unused_top;
   assign unused_top = ^{acc_pick.num[15:IDX_W], bus_wdata[30:NUM_CPUS]};

endmodule

// File: rtl/intc_checker.sv
module intc_checker
   import intc_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned NUM_CPUS  = 4,
   parameter int unsigned ADDR_W    = 14,
   localparam int unsigned CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
   localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_valid,
   input logic                 bus_write,
   input logic [CPU_W-1:0]     bus_cpu,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [31:0]          bus_wdata,
   input logic [31:0]          bus_rdata,
   input logic [NUM_CPUS-1:0]  cpu_irq,
   input logic [NUM_LINES-1:0] mask_q
);

   logic [31:0] a32;
   logic        ev_rd;
   logic        mset_wr;
   logic [(1<<CPU_W)-1:0] irq_ext;
   assign a32     = 32'(bus_addr);
   assign ev_rd   = bus_valid & ~bus_write & (a32 == OFS_EVENT);
   assign mset_wr = bus_valid & bus_write & (a32 >= OFS_MSET) & (a32 < OFS_MCLR);
   assign irq_ext = (1 << CPU_W)'(cpu_irq);

   // R10: idle processor reads an empty event
   assert_idle_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && !irq_ext[bus_cpu]) |-> (bus_rdata == 32'd0));

   // R10: requesting processor reads a nonzero event
   assert_busy_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && irq_ext[bus_cpu]) |-> (bus_rdata != 32'd0));

   // R7: reported line is masked in the next cycle
   assert_auto_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && bus_rdata[23:16] == EVT_TYPE_HW) |=> mask_q[$past(bus_rdata[IDX_W-1:0])]);

   // R7: empty event read changes no mask
   assert_empty_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && bus_rdata == 32'd0) |=> $stable(mask_q));

   // R6: hardware events name an implemented line, die field zero
   assert_hw_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && bus_rdata[23:16] == EVT_TYPE_HW) |->
         (bus_rdata[31:24] == 8'd0 && 32'(bus_rdata[15:0]) < NUM_LINES));

   // R6: inter-processor events carry number 1 or 2
   assert_ipi_num_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && bus_rdata[23:16] == EVT_TYPE_IPI) |->
         (bus_rdata[15:0] == IPI_NUM_OTHER || bus_rdata[15:0] == IPI_NUM_SELF));

   // R3: a zero write to a mask-set word leaves every mask alone
   assert_zero_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mset_wr && bus_wdata == 32'd0) |=> $stable(mask_q));

   // R2: info register reports the line count
   assert_info_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && a32 == OFS_INFO) |-> (bus_rdata == 32'(NUM_LINES)));

endmodule

bind autoack_intc intc_checker #(
   .NUM_LINES(NUM_LINES),
   .NUM_CPUS (NUM_CPUS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_valid(bus_valid),
   .bus_write(bus_write),
   .bus_cpu  (bus_cpu),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .cpu_irq  (cpu_irq),
   .mask_q   (line_mask)
);

// File: tb/sim_autoack_intc.sv
`timescale 1ns/1ps
module sim_autoack_intc;

   localparam int unsigned NL = 40;
   localparam int unsigned NC = 4;
   localparam int unsigned AW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [1:0]    bus_cpu = '0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NL-1:0] hw_irq = '0;
   logic [NC-1:0] cpu_irq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   autoack_intc #(.NUM_LINES(NL), .NUM_CPUS(NC), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .hw_irq(hw_irq), .cpu_irq(cpu_irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int cpu, input int addr, input logic [31:0] data);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = 2'(cpu);
      bus_addr = AW'(addr); bus_wdata = data;
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_rd(input int cpu, input int addr, output logic [31:0] data);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = 2'(cpu); bus_addr = AW'(addr);
      #1 data = bus_rdata;
      @(posedge clk); #1;
      bus_valid = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int cpu, input int addr, input logic [31:0] exp);
      logic [31:0] d;
      bus_rd(cpu, addr, d);
      chk(req, d, exp);
   endtask

   task automatic set_hw(input int line, input logic v);
      @(negedge clk);
      hw_irq[line] = v;
      #1;
   endtask

   task automatic t_reset();
      chk("R1 cpu_irq after reset", 32'(cpu_irq), 32'h0);
      rd_chk("R2 info", 0, 'h000, 32'd40);
      rd_chk("R2 whoami", 3, 'h004, 32'd3);
      rd_chk("R1 mask word0", 0, 'h100, 32'hFFFF_FFFF);
      rd_chk("R1 mask word1", 0, 'h184, 32'h0000_00FF);
      rd_chk("R1 sw word0", 0, 'h200, 32'h0);
      rd_chk("R1 target line39", 0, 'h109C, 32'h1);
      rd_chk("R1 empty event", 0, 'h008, 32'h0);
      bus_wr(0, 'h00C, 32'h2);
      chk("R1 ipi masked at reset", 32'(cpu_irq), 32'h0);
      bus_wr(1, 'h010, 32'h1);
   endtask

   task automatic t_mask();
      set_hw(3, 1'b1);
      chk("R10 masked line no irq", 32'(cpu_irq), 32'h0);
      bus_wr(0, 'h180, 32'h8);
      chk("R10 unmasked line irq", 32'(cpu_irq), 32'h1);
      rd_chk("R3 mask clear word0", 0, 'h100, 32'hFFFF_FFF7);
      bus_wr(0, 'h100, 32'h0);
      rd_chk("R3 zero write no effect", 0, 'h180, 32'hFFFF_FFF7);
      rd_chk("R6 event line3", 0, 'h008, 32'h0001_0003);
      rd_chk("R7 auto mask line3", 0, 'h100, 32'hFFFF_FFFF);
      chk("R7 irq drops after read", 32'(cpu_irq), 32'h0);
      rd_chk("R7 empty read", 0, 'h008, 32'h0);
      rd_chk("R7 empty read no mask change", 0, 'h100, 32'hFFFF_FFFF);
      bus_wr(0, 'h180, 32'h8);
      bus_wr(0, 'h100, 32'h8);
      rd_chk("R3 mask set word0", 0, 'h100, 32'hFFFF_FFFF);
      set_hw(3, 1'b0);
   endtask

   task automatic t_prio();
      set_hw(10, 1'b1);
      set_hw(35, 1'b1);
      bus_wr(0, 'h184, 32'h8);
      bus_wr(0, 'h180, 32'h400);
      rd_chk("R6 lowest line first", 0, 'h008, 32'h0001_000A);
      rd_chk("R6 next line", 0, 'h008, 32'h0001_0023);
      rd_chk("R6 none left", 0, 'h008, 32'h0);
      rd_chk("R7 word1 masked", 0, 'h184, 32'h0000_00FF);
      set_hw(10, 1'b0);
      set_hw(35, 1'b0);
   endtask

   task automatic t_sw();
      bus_wr(0, 'h200, 32'h0010_0000);
      rd_chk("R4 sw set readback", 0, 'h280, 32'h0010_0000);
      bus_wr(0, 'h180, 32'h0010_0000);
      chk("R4 sw pending irq", 32'(cpu_irq), 32'h1);
      rd_chk("R4 sw event", 0, 'h008, 32'h0001_0014);
      bus_wr(0, 'h280, 32'h0010_0000);
      rd_chk("R4 sw clear readback", 0, 'h200, 32'h0);
      bus_wr(0, 'h180, 32'h0010_0000);
      chk("R4 sw cleared no irq", 32'(cpu_irq), 32'h0);
      rd_chk("R4 sw cleared no event", 0, 'h008, 32'h0);
      set_hw(7, 1'b1);
      bus_wr(0, 'h180, 32'h80);
      chk("R4 level pending", 32'(cpu_irq), 32'h1);
      set_hw(7, 1'b0);
      rd_chk("R4 level not latched", 0, 'h008, 32'h0);
      bus_wr(0, 'h100, 32'h0010_0080);
   endtask

   task automatic t_target();
      bus_wr(0, 'h1030, 32'h4);
      rd_chk("R5 target readback", 1, 'h1030, 32'h4);
      set_hw(12, 1'b1);
      bus_wr(0, 'h180, 32'h1000);
      chk("R5 routed irq", 32'(cpu_irq), 32'h4);
      rd_chk("R5 other cpu sees nothing", 0, 'h008, 32'h0);
      rd_chk("R11 target cpu event", 2, 'h008, 32'h0001_000C);
      set_hw(12, 1'b0);
      bus_wr(0, 'h1030, 32'h1);
   endtask

   task automatic t_ipi();
      bus_wr(0, 'h103C, 32'h2);
      set_hw(15, 1'b1);
      bus_wr(0, 'h180, 32'h8000);
      chk("R5 line15 to cpu1", 32'(cpu_irq), 32'h2);
      bus_wr(1, 'h018, 32'h8000_0001);
      bus_wr(0, 'h00C, 32'h2);
      rd_chk("R6 ipi ahead of lines", 1, 'h008, 32'h0004_0001);
      rd_chk("R9 ipi masked after read", 1, 'h008, 32'h0001_000F);
      bus_wr(1, 'h018, 32'h1);
      rd_chk("R9 ipi still pending", 1, 'h008, 32'h0004_0001);
      bus_wr(1, 'h010, 32'h1);
      bus_wr(1, 'h018, 32'h1);
      chk("R8 ack clears pending", 32'(cpu_irq), 32'h0);
      bus_wr(1, 'h00C, 32'h8000_0000);
      chk("R11 self goes to sender", 32'(cpu_irq), 32'h2);
      rd_chk("R11 cpu0 unaffected", 0, 'h008, 32'h0);
      bus_wr(3, 'h00C, 32'h2);
      rd_chk("R6 other before self", 1, 'h008, 32'h0004_0001);
      rd_chk("R6 self event", 1, 'h008, 32'h0004_0002);
      bus_wr(1, 'h010, 32'h8000_0001);
      bus_wr(1, 'h018, 32'h8000_0001);
      chk("R8 both acked", 32'(cpu_irq), 32'h0);
      bus_wr(2, 'h00C, 32'h2);
      chk("R8 send sets pending", 32'(cpu_irq), 32'h2);
      bus_wr(1, 'h014, 32'h1);
      chk("R8 ipi mask set", 32'(cpu_irq), 32'h0);
      bus_wr(1, 'h010, 32'h1);
      set_hw(15, 1'b0);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_prio();
      t_sw();
      t_target();
      t_ipi();
      finished = 1'b1;
      finish_run();
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_run();
      end
   end

endmodule